// File: doc/BRIEF.md
# Coprocessor Instruction Dispatch Controller

This block sits on the processor side of a coprocessor link. When the decoder meets an opcode that the core cannot execute, it hands the block the instruction word and a pass/fail bit from the condition check. If the condition fails, the instruction is dropped quietly. If it passes, the block raises one strobe that every attached coprocessor watches and drives the instruction word onto a shared bus. It then waits for a claim on an active-low, wired claim line.

A coprocessor that claims the instruction may also hold a busy line. While busy is high, the block keeps the strobe up and stalls the core. If no coprocessor claims the instruction within the claim window, the block asks for an undefined-instruction exception. Fetching operands and moving data are left to other logic. The reset is synchronous and active-low.

Top module: `cop_dispatch`

## Requirements
- R1: A cycle with `rst_n` low forces the controller idle at the next edge: `cp_req`, `core_stall` and `undef_trap` are low, and `cp_bus` is all zeros.
- R2: If `cp_accept_n` is still high at the edge that closes the claim window, the controller drops `cp_req` and pulses `undef_trap` high for exactly one cycle. It then returns to idle.
- R3: An `undef_valid` taken while idle with `cond_pass` low produces no `cp_req`, no `core_stall` and no `undef_trap`. The controller stays idle.
- R4: An `undef_valid` taken while idle with `cond_pass` high raises `cp_req` and `core_stall` from the next cycle. They stay high for `CLAIM_LAT` cycles, which form the claim window. `cp_accept_n` is sampled at the last edge of that window.
- R5: While `cp_req` is high, `cp_bus` holds the `instr_word` that was captured with `undef_valid`, even if `instr_word` changes. While `cp_req` is low, `cp_bus` is zero.
- R6: If the instruction is claimed (`cp_accept_n` low) and `cp_busy` is high at the window's last edge, `cp_req` and `core_stall` stay high until the first edge at which `cp_busy` is sampled low.
- R7: When a claimed instruction completes (claimed with `cp_busy` low, or busy released), there is one cycle with `cp_req`, `core_stall` and `undef_trap` all low, and no trap is raised. The controller is then idle.
- R8: `undef_valid` is ignored in every state other than idle. No second strobe follows the current instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| undef_valid | input | 1 | Decoder reports an opcode the core does not implement |
| instr_word | input | IW | Instruction word that comes with `undef_valid` |
| cond_pass | input | 1 | Result of the predicate condition check for that instruction |
| cp_accept_n | input | 1 | Wired claim line, low when some coprocessor accepts |
| cp_busy | input | 1 | Claiming coprocessor still working |
| cp_req | output | 1 | Coprocessor-instruction strobe to all coprocessors |
| cp_bus | output | IW | Instruction word to the coprocessors, zero when not requesting |
| core_stall | output | 1 | Holds the core pipeline |
| undef_trap | output | 1 | One-cycle undefined-instruction exception request |

## Verification
The embedded assertions check the following on every cycle:
- the reset response;
- the silence after a failed condition;
- that a trap is preceded only by an unclaimed strobe and lasts a single cycle;
- that the bus is stable while the strobe is up;
- that a busy claimant keeps the core stalled;
- that the claim counter stays inside its window.

Only the bench scenarios can show the rest:
- the exact cycle counts of the whole exchange;
- that the bus carries the captured word and not a changed input;
- that the done cycle is clean;
- that a request arriving mid-exchange leaves no second strobe.

// File: rtl/cop_dispatch_pkg.sv
// Package: shared types for the coprocessor dispatch controller.
// Assumes: nothing; pure type definitions.
package cop_dispatch_pkg;

    // Sequencer states; the encoding is internal only
    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_BCAST     = 3'd1,
        ST_WAIT_BUSY = 3'd2,
        ST_DONE      = 3'd3,
        ST_TRAP      = 3'd4
    } disp_state_t;

endpackage

// File: rtl/cop_claim_window.sv
// Module: counts the cycles of the claim window while the strobe is up.
// Assumes: active stays high from the first window cycle until the decision;
//          LAT >= 1.
module cop_claim_window #(
    parameter int LAT = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic window_end
);
    localparam int CW = (LAT < 2) ? 1 : $clog2(LAT + 1);
    localparam logic [CW-1:0] LAST = CW'(LAT - 1);

    logic [CW-1:0] cnt_q;

    // Purpose: cycle counter, cleared whenever the window is inactive
    always_ff @(posedge clk) begin
        if (!rst_n || !active) cnt_q <= '0;
        else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
    end

    // Purpose: flag the final cycle of the window
    always_comb window_end = active && (cnt_q == LAST);

    assert_window_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt_q <= LAST));
endmodule

// File: rtl/cop_word_latch.sv
// Module: captures the instruction word and presents it on the coprocessor bus.
// Assumes: capture is high only in the cycle an instruction is accepted.
module cop_word_latch #(
    parameter int IW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic [IW-1:0] word_in,
    input  logic          drive,
    output logic [IW-1:0] bus_out
);
    logic [IW-1:0] word_q;

    // Purpose: hold the accepted word until the next accepted instruction
    always_ff @(posedge clk) begin
        if (!rst_n)       word_q <= '0;
        else if (capture) word_q <= word_in;
    end

    // Purpose: put the word on the bus only while the strobe is up
    always_comb bus_out = drive ? word_q : '0;

    assert_bus_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (drive && $past(drive)) |-> $stable(bus_out));
endmodule

// File: rtl/cop_seq_fsm.sv
// Module: dispatch sequencer (idle, broadcast, wait-busy, done, trap).
// Assumes: window_end comes from a counter that is active in ST_BCAST;
//          cp_accept_n is low when some coprocessor is claiming.
module cop_seq_fsm
    import cop_dispatch_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        undef_valid,
    input  logic        cond_pass,
    input  logic        window_end,
    input  logic        cp_accept_n,
    input  logic        cp_busy,
    output disp_state_t state,
    output logic        capture,
    output logic        req,
    output logic        stall,
    output logic        trap
);
    disp_state_t st_q, st_d;

    // Purpose: next-state selection
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:      if (undef_valid && cond_pass) st_d = ST_BCAST;
            ST_BCAST:     if (window_end) begin
                              if (cp_accept_n) st_d = ST_TRAP;
                              else if (cp_busy) st_d = ST_WAIT_BUSY;
                              else st_d = ST_DONE;
                          end
            ST_WAIT_BUSY: if (!cp_busy) st_d = ST_DONE;
            ST_DONE:      st_d = ST_IDLE;
            ST_TRAP:      st_d = ST_IDLE;
            default:      st_d = ST_IDLE;
        endcase
    end

    // Purpose: state register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Purpose: decode outputs from the current state
    always_comb begin
        state   = st_q;
        capture = (st_q == ST_IDLE) && undef_valid && cond_pass;
        req     = (st_q == ST_BCAST) || (st_q == ST_WAIT_BUSY);
        stall   = req;
        trap    = (st_q == ST_TRAP);
    end

    assert_cond_fail_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && undef_valid && !cond_pass) |=> (!req && !trap));
    assert_busy_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT_BUSY && cp_busy) |=> (req && stall));
    assert_busy_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (window_end && !cp_accept_n && cp_busy) |=> (st_q == ST_WAIT_BUSY));
endmodule

// File: rtl/cop_dispatch.sv
// Module: top of the coprocessor dispatch controller.
// Assumes: undef_valid is a single-cycle event from the decoder; the core does
//          not issue new events while core_stall is high.
module cop_dispatch
    import cop_dispatch_pkg::*;
#(
    parameter int IW        = 32,
    parameter int CLAIM_LAT = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          undef_valid,
    input  logic [IW-1:0] instr_word,
    input  logic          cond_pass,
    input  logic          cp_accept_n,
    input  logic          cp_busy,
    output logic          cp_req,
    output logic [IW-1:0] cp_bus,
    output logic          core_stall,
    output logic          undef_trap
);
    disp_state_t state;
    logic        capture;
    logic        window_end;
    logic        in_bcast;

    // Purpose: the claim window runs only in the broadcast state
    always_comb in_bcast = (state == ST_BCAST);

    cop_claim_window #(.LAT(CLAIM_LAT)) win_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (in_bcast),
        .window_end (window_end)
    );

    cop_seq_fsm fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .undef_valid (undef_valid),
        .cond_pass   (cond_pass),
        .window_end  (window_end),
        .cp_accept_n (cp_accept_n),
        .cp_busy     (cp_busy),
        .state       (state),
        .capture     (capture),
        .req         (cp_req),
        .stall       (core_stall),
        .trap        (undef_trap)
    );

    cop_word_latch #(.IW(IW)) latch_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .word_in (instr_word),
        .drive   (cp_req),
        .bus_out (cp_bus)
    );

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (!cp_req && !core_stall && !undef_trap));
    assert_trap_unclaimed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        undef_trap |-> ($past(cp_req) && $past(cp_accept_n)));
    assert_trap_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        undef_trap |=> !undef_trap);
    assert_req_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cp_req) |-> $past(undef_valid && cond_pass));
endmodule

// File: tb/cop_dispatch_tb.sv
module cop_dispatch_tb_top;
    localparam int IW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          undef_valid = 1'b0;
    logic [IW-1:0] instr_word = '0;
    logic          cond_pass = 1'b0;
    logic          cp_accept_n = 1'b1;
    logic          cp_busy = 1'b0;
    logic          cp_req;
    logic [IW-1:0] cp_bus;
    logic          core_stall;
    logic          undef_trap;

    int n_checks = 0;
    int n_errors = 0;

    cop_dispatch #(.IW(IW), .CLAIM_LAT(1)) dut_i (
        .clk(clk), .rst_n(rst_n), .undef_valid(undef_valid), .instr_word(instr_word),
        .cond_pass(cond_pass), .cp_accept_n(cp_accept_n), .cp_busy(cp_busy),
        .cp_req(cp_req), .cp_bus(cp_bus), .core_stall(core_stall), .undef_trap(undef_trap)
    );

    always #5 clk = ~clk;

    // Packs the three control outputs as {cp_req, core_stall, undef_trap}
    function automatic logic [2:0] ctl_exp(input logic req, input logic trap);
        return {req, req, trap};
    endfunction

    task automatic chk(input string tag, input logic [IW-1:0] act, input logic [IW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_ctl(input string tag, input logic req, input logic trap);
        chk(tag, {29'd0, cp_req, core_stall, undef_trap}, {29'd0, ctl_exp(req, trap)});
    endtask

    // One instruction; inject=1 pulses undef_valid during the busy phase (R8)
    task automatic run_txn(input logic cond, input logic acc, input int nbusy,
                           input logic [IW-1:0] word, input logic inject);
        @(negedge clk);
        undef_valid = 1'b1; instr_word = word; cond_pass = cond;
        cp_accept_n = 1'b1; cp_busy = 1'b0;
        @(negedge clk);
        undef_valid = 1'b0; instr_word = ~word;
        if (!cond) begin
            chk_ctl("R3 quiet on failed condition", 1'b0, 1'b0);
            chk("R5 bus zero when idle", cp_bus, '0);
            @(negedge clk);
            chk_ctl("R3 still idle", 1'b0, 1'b0);
            return;
        end
        chk_ctl("R4 strobe and stall", 1'b1, 1'b0);
        chk("R5 bus carries captured word", cp_bus, word);
        cp_accept_n = !acc;
        cp_busy = acc && (nbusy > 0);
        @(negedge clk);
        cp_accept_n = 1'b1;
        if (!acc) begin
            chk_ctl("R2 trap when unclaimed", 1'b0, 1'b1);
            @(negedge clk);
            chk_ctl("R2 trap single cycle", 1'b0, 1'b0);
            return;
        end
        for (int i = 1; i <= nbusy; i++) begin
            chk_ctl("R6 held while busy", 1'b1, 1'b0);
            chk("R5 bus held while busy", cp_bus, word);
            if (inject && i == 1) begin
                undef_valid = 1'b1; cond_pass = 1'b1; instr_word = 32'hDEAD_BEEF;
            end else begin
                undef_valid = 1'b0;
            end
            if (i == nbusy) cp_busy = 1'b0;
            @(negedge clk);
        end
        undef_valid = 1'b0;
        chk_ctl("R7 done cycle clean", 1'b0, 1'b0);
        @(negedge clk);
        chk_ctl("R7 idle after done", 1'b0, 1'b0);
        if (inject) begin
            @(negedge clk);
            chk_ctl("R8 no second strobe", 1'b0, 1'b0);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk_ctl("R1 reset state", 1'b0, 1'b0);
        chk("R1 bus zero in reset", cp_bus, '0);
        rst_n = 1'b1;

        run_txn(1'b1, 1'b1, 0, 32'h1234_5678, 1'b0);
        run_txn(1'b1, 1'b0, 0, 32'hA5A5_0001, 1'b0);
        run_txn(1'b0, 1'b1, 2, 32'hFFFF_FFFF, 1'b0);
        run_txn(1'b1, 1'b1, 3, 32'h0F0F_F0F0, 1'b1);
        run_txn(1'b1, 1'b1, 1, 32'h0000_0001, 1'b0);

        // Reset in the middle of a busy exchange (R1)
        @(negedge clk);
        undef_valid = 1'b1; cond_pass = 1'b1; instr_word = 32'h7777_0000;
        @(negedge clk);
        undef_valid = 1'b0; cp_accept_n = 1'b0; cp_busy = 1'b1;
        @(negedge clk);
        chk_ctl("R6 busy entered", 1'b1, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        chk_ctl("R1 reset mid exchange", 1'b0, 1'b0);
        chk("R1 bus cleared", cp_bus, '0);
        rst_n = 1'b1; cp_accept_n = 1'b1; cp_busy = 1'b0;

        for (int k = 0; k < 60; k++) begin
            run_txn(($urandom % 4) != 0, ($urandom % 3) != 0, int'($urandom % 4),
                    $urandom, ($urandom % 5) == 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule